// File: doc/BRIEF.md
# Configurable Serial Audio Input Receiver

This block is a clock-slave receiver for stereo PCM audio. It listens to an external bit clock and an external frame clock, and it shares them across several serial data pins. Each pin carries two channels, sent one after the other with the most significant bit first. At run time the block can be set to standard I2S framing or left-justified framing. It can also be set to sample on either edge of the bit clock, and to swap which frame-clock level means the first channel.

The bit clock, the frame clock and the data pins are brought into the system clock domain through a synchronizer chain of equal depth on every line. The bit-clock edge used for sampling is detected on the synchronized copy. A per-subframe bit position tells each lane which bit of its word the current sample fills. When the next frame-clock change marks the end of a subframe, every lane presents its word in parallel. The words carry one shared channel tag and a one-cycle valid strobe. A programmable sample width sets how many leading bits are kept. The system clock must run at four or more times the bit-clock rate.

Top module: `sai_rx`

## Requirements
- R1: With I2S framing (cfg_fmt_lj=0), the MSB of a subframe is the bit sampled on the second active bit-clock edge after the frame clock changes level. With cfg_lr_swap=0, frame clock low marks channel 0 (left).
- R2: With left-justified framing (cfg_fmt_lj=1), the MSB is the bit sampled on the first active bit-clock edge after the frame clock changes level. With cfg_lr_swap=0, frame clock high marks channel 0 (left).
- R3: With cfg_fall_edge=0, data and frame clock are sampled on bit-clock rising edges. With cfg_fall_edge=1, they are sampled on falling edges.
- R4: cfg_lr_swap=1 inverts the channel tag reported for every subframe, in both framings.
- R5: cfg_width selects the captured sample width. Values below 16 act as 16, and values above 32 act as 32. The first width bits of a subframe land in out_data bits [31 down to 32-width] of the lane. Lower bits read 0, and any bits clocked after the LSB have no effect.
- R6: Each of the 5 data pins is deserialized independently on the common clock pair. Lane k appears at out_data[32k+31:32k], and all lanes are presented with the same strobe.
- R7: out_valid is high for exactly one system clock. It rises on the 3rd system clock rising edge after the active bit-clock edge that closes the subframe, so it is seen in the cycle that follows that 3rd edge.
- R8: After reset, out_valid, out_chan and out_data are 0. The subframe in progress when the first frame-clock change is seen is never emitted, and every later complete subframe is emitted once.
- R9: While out_valid is low, out_data and out_chan keep their last emitted values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | External serial bit clock |
| lrck_in | input | 1 | External frame (left/right) clock |
| sdata_in | input | 5 | Serial data pins, one per lane |
| cfg_fmt_lj | input | 1 | 0 = I2S framing, 1 = left-justified framing |
| cfg_fall_edge | input | 1 | 0 = sample on bit-clock rise, 1 = on fall |
| cfg_lr_swap | input | 1 | Inverts the channel tag |
| cfg_width | input | 6 | Requested sample width in bits |
| out_valid | output | 1 | One-cycle strobe: a new set of words is presented |
| out_chan | output | 1 | Channel tag of the presented words (0 = left) |
| out_data | output | 160 | Left-aligned words, 32 bits per lane |

## Verification
A word set is due exactly three system clocks after the bit-clock edge that closes its subframe. For left-justified framing, that is the first active edge after the frame clock changes. For I2S framing, it is the second active edge. The bench records the cycle count at the moment it drives each closing edge. It compares the count at every observed strobe against that record plus three, and it samples all outputs on falling system-clock edges. After each stream it waits for the last strobe, then confirms that no word set is missing or extra and that the outputs have held their final values.

// File: rtl/sai_pkg.sv
`timescale 1ns/1ps
package sai_pkg;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_LJ  = 1'b1
  } sai_fmt_e;

  // Channel tag of a subframe from the framing level that bounds it.
  // I2S: low level is channel 0; left-justified: high level is channel 0.
  function automatic logic chan_of(input logic lr, input sai_fmt_e fmt, input logic swap);
    logic base;
    base = (fmt == FMT_LJ) ? ~lr : lr;
    return base ^ swap;
  endfunction

endpackage

// File: rtl/sai_sync.sv
`timescale 1ns/1ps
module sai_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  // Every line passes through the same depth, so the lines keep their
  // relative timing as seen from the bit clock.
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sai_framer.sv
`timescale 1ns/1ps
module sai_framer
  import sai_pkg::*;
#(
  parameter int SAMPLE_BITS = 32,
  parameter int MIN_BITS    = 16,
  parameter int CFG_W       = 6,
  parameter int POS_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_s,
  input  logic             lrck_s,
  input  sai_fmt_e         fmt,
  input  logic             fall_edge,
  input  logic             lr_swap,
  input  logic [CFG_W-1:0] width_req,
  output logic             samp_evt,
  output logic             frame_edge,
  output logic             emit,
  output logic [POS_W-1:0] cur_slot,
  output logic [POS_W-1:0] width_eff,
  output logic             out_valid,
  output logic             out_chan
);

  function automatic logic [POS_W-1:0] clamp_width(input logic [CFG_W-1:0] req);
    logic [POS_W-1:0] r;
    r = POS_W'(req);
    if (r < POS_W'(MIN_BITS))         return POS_W'(MIN_BITS);
    else if (r > POS_W'(SAMPLE_BITS)) return POS_W'(SAMPLE_BITS);
    else                              return r;
  endfunction

  function automatic logic [POS_W-1:0] sat_inc(input logic [POS_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  logic             bclk_q;
  logic             lr_d;
  logic             fr_prev;
  logic             fr_now;
  logic [1:0]       hist;
  logic             synced;
  logic             chan_cur;
  logic [POS_W-1:0] bitpos;
  logic             bclk_rise;
  logic             bclk_fall;

  always_comb begin
    bclk_rise  = bclk_s & ~bclk_q;
    bclk_fall  = ~bclk_s & bclk_q;
    samp_evt   = fall_edge ? bclk_fall : bclk_rise;
    // I2S framing is left-justified framing with the frame clock seen one bit later.
    fr_now     = (fmt == FMT_LJ) ? lrck_s : lr_d;
    frame_edge = samp_evt && (hist == 2'd2) && (fr_now != fr_prev);
    emit       = frame_edge && synced;
    cur_slot   = frame_edge ? '0 : sat_inc(bitpos);
    width_eff  = clamp_width(width_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      lr_d      <= 1'b0;
      fr_prev   <= 1'b0;
      hist      <= 2'd0;
      synced    <= 1'b0;
      chan_cur  <= 1'b0;
      bitpos    <= '0;
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
    end else begin
      bclk_q    <= bclk_s;
      out_valid <= 1'b0;
      if (samp_evt) begin
        lr_d    <= lrck_s;
        fr_prev <= fr_now;
        bitpos  <= cur_slot;
        if (hist != 2'd2) hist <= hist + 2'd1;
        if (frame_edge) begin
          synced   <= 1'b1;
          chan_cur <= chan_of(fr_now, fmt, lr_swap);
        end
        if (emit) begin
          out_valid <= 1'b1;
          out_chan  <= chan_cur;
        end
      end
    end
  end

  // R3: with the system clock at four or more times the bit clock, active edges are never back to back
  a_r3_evt_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    samp_evt |=> !samp_evt);

  // R7: the strobe lasts one system clock
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8: a strobe only follows a subframe that began after synchronization
  a_r8_emit_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(synced));

  // R8: the frame-clock change that synchronizes the receiver emits nothing
  a_r8_first_edge_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> !out_valid);

endmodule

// File: rtl/sai_lane.sv
`timescale 1ns/1ps
module sai_lane #(
  parameter int SAMPLE_BITS = 32,
  parameter int POS_W       = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   samp_evt,
  input  logic                   frame_edge,
  input  logic                   emit,
  input  logic [POS_W-1:0]       cur_slot,
  input  logic [POS_W-1:0]       width_eff,
  input  logic                   din,
  output logic [SAMPLE_BITS-1:0] word
);

  // One-hot position in the left-aligned word for bit number slot of a subframe.
  function automatic logic [SAMPLE_BITS-1:0] slot_onehot(input logic [POS_W-1:0] slot);
    logic [SAMPLE_BITS-1:0] oh;
    for (int i = 0; i < SAMPLE_BITS; i++)
      oh[i] = (POS_W'(SAMPLE_BITS - 1 - i) == slot);
    return oh;
  endfunction

  // Bits of the left-aligned word that a width of w may set.
  function automatic logic [SAMPLE_BITS-1:0] keep_mask(input logic [POS_W-1:0] w);
    logic [SAMPLE_BITS-1:0] m;
    for (int i = 0; i < SAMPLE_BITS; i++)
      m[i] = (POS_W'(SAMPLE_BITS - 1 - i) < w);
    return m;
  endfunction

  logic [SAMPLE_BITS-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      word <= '0;
    end else if (samp_evt) begin
      if (frame_edge) begin
        if (emit) word <= acc;
        acc <= {din, {(SAMPLE_BITS-1){1'b0}}};
      end else if (din && (cur_slot < width_eff)) begin
        acc <= acc | slot_onehot(cur_slot);
      end
    end
  end

  // R5: a completed word never carries bits beyond the selected width
  a_r5_tail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_evt && emit) |-> ((acc & ~keep_mask(width_eff)) == '0));

endmodule

// File: rtl/sai_rx.sv
`timescale 1ns/1ps
module sai_rx
  import sai_pkg::*;
#(
  parameter int NUM_LANES   = 5,
  parameter int SAMPLE_BITS = 32,
  parameter int MIN_BITS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = $clog2(SAMPLE_BITS) + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bclk_in,
  input  logic                             lrck_in,
  input  logic [NUM_LANES-1:0]             sdata_in,
  input  logic                             cfg_fmt_lj,
  input  logic                             cfg_fall_edge,
  input  logic                             cfg_lr_swap,
  input  logic [CFG_W-1:0]                 cfg_width,
  output logic                             out_valid,
  output logic                             out_chan,
  output logic [NUM_LANES*SAMPLE_BITS-1:0] out_data
);

  localparam int POS_W  = $clog2(SAMPLE_BITS) + 3;
  localparam int SYNC_W = NUM_LANES + 2;

  logic [SYNC_W-1:0]    sync_bus;
  logic                 bclk_s;
  logic                 lrck_s;
  logic [NUM_LANES-1:0] data_s;
  logic                 samp_evt;
  logic                 frame_edge;
  logic                 emit;
  logic [POS_W-1:0]     cur_slot;
  logic [POS_W-1:0]     width_eff;

  sai_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sdata_in, lrck_in, bclk_in}),
    .sync_out (sync_bus)
  );

  assign bclk_s = sync_bus[0];
  assign lrck_s = sync_bus[1];
  assign data_s = sync_bus[SYNC_W-1:2];

  sai_framer #(
    .SAMPLE_BITS (SAMPLE_BITS),
    .MIN_BITS    (MIN_BITS),
    .CFG_W       (CFG_W),
    .POS_W       (POS_W)
  ) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_s     (bclk_s),
    .lrck_s     (lrck_s),
    .fmt        (sai_fmt_e'(cfg_fmt_lj)),
    .fall_edge  (cfg_fall_edge),
    .lr_swap    (cfg_lr_swap),
    .width_req  (cfg_width),
    .samp_evt   (samp_evt),
    .frame_edge (frame_edge),
    .emit       (emit),
    .cur_slot   (cur_slot),
    .width_eff  (width_eff),
    .out_valid  (out_valid),
    .out_chan   (out_chan)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    sai_lane #(.SAMPLE_BITS(SAMPLE_BITS), .POS_W(POS_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_evt   (samp_evt),
      .frame_edge (frame_edge),
      .emit       (emit),
      .cur_slot   (cur_slot),
      .width_eff  (width_eff),
      .din        (data_s[k]),
      .word       (out_data[k*SAMPLE_BITS +: SAMPLE_BITS])
    );
  end

  // R9: outputs hold between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_data) && $stable(out_chan)));

endmodule

// File: tb/tb_sai_rx.sv
`timescale 1ns/1ps
module tb_sai_rx;
  localparam int NL = 5;
  localparam int SB = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic             bclk, lrck;
  logic [NL-1:0]    sdata;
  logic             cfg_lj, cfg_fall, cfg_swap;
  logic [5:0]       cfg_w;
  logic             out_valid, out_chan;
  logic [NL*SB-1:0] out_data;

  sai_rx dut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .lrck_in(lrck), .sdata_in(sdata),
    .cfg_fmt_lj(cfg_lj), .cfg_fall_edge(cfg_fall), .cfg_lr_swap(cfg_swap),
    .cfg_width(cfg_w), .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string tag    = "";

  logic [SB-1:0] words [0:7][0:NL-1];
  int unsigned   due   [0:7];
  int            got, exp_last;
  bit            exp_lj, exp_swap, lr0;
  int            exp_w;
  logic [SB-1:0] last_word [0:NL-1];
  logic          last_chan;

  function automatic int eff_width(input int req);
    if (req < 16) return 16;
    if (req > 32) return 32;
    return req;
  endfunction

  function automatic logic [SB-1:0] top_bits(input logic [SB-1:0] v, input int w);
    logic [SB-1:0] m;
    m = '1;
    m = m << (SB - w);
    return v & m;
  endfunction

  function automatic logic chan_for(input int n);
    logic lvl;
    lvl = lr0 ^ n[0];
    return exp_lj ? ~lvl ^ exp_swap : lvl ^ exp_swap;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s (%s): actual=%0h expected=%0h", req, what, tag, act, exp);
    end
  endtask

  // Monitor: compares each strobe against the expected word set and its due cycle.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      int n;
      n = 1 + got;
      if (n > exp_last) begin
        chk(1'b0, "R8", "unexpected strobe", 64'd1, 64'd0);
      end else begin
        for (int k = 0; k < NL; k++) begin
          chk(out_data[k*SB +: SB] == top_bits(words[n][k], exp_w), "R6", $sformatf("lane %0d word", k),
              64'(out_data[k*SB +: SB]), 64'(top_bits(words[n][k], exp_w)));
          last_word[k] = out_data[k*SB +: SB];
        end
        chk(out_chan == chan_for(n), tag, "channel tag", 64'(out_chan), 64'(chan_for(n)));
        chk(cyc == due[n] + 3, "R7", "strobe cycle", 64'(cyc), 64'(due[n] + 3));
        last_chan = out_chan;
      end
      got++;
    end
  end

  task automatic do_reset(input bit lj, input bit fall, input bit swap, input int wreq);
    rst_n    = 1'b0;
    cfg_lj   = lj;
    cfg_fall = fall;
    cfg_swap = swap;
    cfg_w    = 6'(wreq);
    bclk     = fall;
    lrck     = 1'b0;
    sdata    = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0 && out_chan == 1'b0, "R8", "reset state",
        64'(out_valid), 64'd0);
  endtask

  task automatic run_stream(input string t, input bit lj, input bit fall, input bit swap,
                            input int wreq, input int slots, input int half, input bit directed);
    localparam int NSUB = 6;
    logic [NL-1:0] dat [0:511];
    int total;
    tag      = t;
    exp_lj   = lj;
    exp_swap = swap;
    exp_w    = eff_width(wreq);
    lr0      = 1'($urandom % 2);
    for (int n = 0; n < NSUB; n++)
      for (int k = 0; k < NL; k++) begin
        if (directed) begin
          case (k)
            0: words[n][k] = 32'hFFFF_FFFF;
            1: words[n][k] = 32'h0000_0000;
            2: words[n][k] = 32'hA5A5_A5A5;
            3: words[n][k] = 32'h8000_0001;
            default: words[n][k] = 32'h0000_0001;
          endcase
          if (n[0]) words[n][k] = ~words[n][k];
        end else begin
          words[n][k] = $urandom;
        end
      end
    total = NSUB * slots + 1;
    for (int g = 0; g < total; g++) dat[g] = NL'($urandom);
    for (int n = 0; n < NSUB; n++)
      for (int j = 0; j < slots && j < SB; j++)
        for (int k = 0; k < NL; k++)
          dat[n*slots + j + (lj ? 0 : 1)][k] = words[n][k][SB-1-j];

    do_reset(lj, fall, swap, wreq);
    got      = 0;
    exp_last = NSUB - 2;
    for (int g = 0; g < NSUB * slots; g++) begin
      int n, j;
      n = g / slots;
      j = g % slots;
      @(negedge clk);
      lrck  = lr0 ^ n[0];
      sdata = dat[g];
      bclk  = fall;
      repeat (half) @(negedge clk);
      bclk = ~fall;  // active edge
      if (n >= 2 && j == (lj ? 0 : 1)) due[n-1] = cyc;
      repeat (half - 1) @(negedge clk);
    end
    repeat (half + 10) @(negedge clk);
    chk(got == exp_last, "R8", "word sets emitted", 64'(got), 64'(exp_last));
    for (int k = 0; k < NL; k++)
      chk(out_data[k*SB +: SB] == last_word[k], "R9", $sformatf("lane %0d held", k),
          64'(out_data[k*SB +: SB]), 64'(last_word[k]));
    chk(out_chan == last_chan, "R9", "channel held", 64'(out_chan), 64'(last_chan));
  endtask

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; bclk = 1'b0; lrck = 1'b0; sdata = '0;
    cfg_lj = 1'b0; cfg_fall = 1'b0; cfg_swap = 1'b0; cfg_w = 6'd32;
    got = 0; exp_last = 0; exp_w = 32;
    // directed corners
    run_stream("R1", 1'b0, 1'b0, 1'b0, 32, 32, 2, 1'b0);
    run_stream("R2", 1'b1, 1'b0, 1'b0, 32, 32, 2, 1'b0);
    run_stream("R3", 1'b0, 1'b1, 1'b0, 24, 32, 3, 1'b0);
    run_stream("R4", 1'b1, 1'b0, 1'b1, 32, 40, 2, 1'b0);
    run_stream("R4", 1'b0, 1'b1, 1'b1, 28, 32, 2, 1'b0);
    run_stream("R5", 1'b1, 1'b1, 1'b0, 16, 24, 2, 1'b0);
    run_stream("R5", 1'b0, 1'b0, 1'b0, 8,  32, 2, 1'b0);
    run_stream("R5", 1'b1, 1'b0, 1'b0, 50, 36, 2, 1'b0);
    run_stream("R6", 1'b0, 1'b0, 1'b0, 32, 32, 2, 1'b1);
    // constrained random
    for (int r = 0; r < 6; r++) begin
      int w, s;
      w = 10 + int'($urandom % 30);
      s = eff_width(w) + int'($urandom % 9);
      run_stream("R7", 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                 w, s, 2 + int'($urandom % 2), 1'b0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule